// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a synchronous host and an 8192 x 8 asynchronous static RAM. The host issues single-beat read or write requests on a valid/ready handshake. The block turns each request into a strobe sequence on the memory bus, timed in whole clock cycles. The memory bus has a 13-bit address, two chip selects of opposite polarity, a read (output) enable and a write enable. The shared data lines appear as separate drive value, drive enable and sampled input signals, and a pad ring combines them into one bidirectional bus.

A write asserts both selects and presents address and data with the write enable still high. It then pulls the write enable low for the pulse window and ends the write by raising the write enable while both selects stay active. The address and data are held for one further cycle. The data bus is then released and the selects drop.

A read asserts both selects and the read enable for a programmed access count, with the write enable high. It samples the data lines on the clock edge that closes the access count. It returns the byte with a single-cycle response pulse. A request is taken only while the sequencer is idle, and every timing parameter must be at least 1.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, both chip selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_rd_n`=1, `mem_wr_n`=1, `mem_dout_en`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. An accepted write keeps `req_ready` low for exactly T_ASU + max(T_WP, T_DSU) + 2 cycles.
- R3: A write starts with T_ASU cycles in which both selects are active, `mem_wr_n` and `mem_rd_n` are high, and the block drives the data bus.
- R4: The write pulse holds `mem_wr_n` low for max(T_WP, T_DSU) cycles while both selects stay active and address and data stay stable. The write ends when `mem_wr_n` rises with both selects still active.
- R5: In the cycle after `mem_wr_n` rises, the selects stay active and address and data are unchanged on a driven bus. In the next cycle the bus is released and both selects go inactive.
- R6: `mem_dout_en` and an active-low `mem_rd_n` are never high and low in the same cycle.
- R7: A read keeps `mem_rd_n` low for exactly T_RD cycles, with both selects active, `mem_wr_n` high and the bus not driven.
- R8: The byte on `mem_din` is captured on the edge that ends the access count. `rsp_valid` is high for exactly one cycle, the cycle after the last access cycle, with the byte on `rsp_rdata`.
- R9: In the cycle after `mem_dout_en` was high, `mem_rd_n` is high.
- R10: A read returns the byte last written to its address, across the whole address range including 0 and 8191.
- R11: The cycle that carries `rsp_valid` is an idle cycle, so a new request presented in that cycle is accepted on its closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low output enable of the memory |
| mem_wr_n | output | 1 | Active-low write enable |
| mem_dout | output | DATA_W | Value driven onto the data bus |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Sampled data bus |

## Verification
Two functions can fall in the same cycle. The response pulse of one read can coincide with the acceptance of the next request, and bus release after a write can sit next to the start of a read. The bench provokes the first by raising the next read in the very cycle it sees `rsp_valid`. It then judges the second response by its latency, its data and the width of its pulse. It provokes the second with a write followed at once by a read of the same address. A monitor flags any cycle where the read enable is low while the bus is driven, or in the cycle right after it was driven.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD,
        ST_WTURN,
        ST_RACC
    } seq_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic rd_n;
        logic wr_n;
        logic dout_en;
    } strobe_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t decode_strobes(input seq_state_e st);
        strobe_t s;
        logic active;
        active    = (st == ST_WSET) || (st == ST_WPULSE) || (st == ST_WHOLD) || (st == ST_RACC);
        s.sel_n   = ~active;
        s.sel     = active;
        s.rd_n    = (st != ST_RACC);
        s.wr_n    = (st != ST_WPULSE);
        s.dout_en = (st == ST_WSET) || (st == ST_WPULSE) || (st == ST_WHOLD);
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned T_ASU     = 1,
    parameter int unsigned PULSE_LEN = 2,
    parameter int unsigned T_RD      = 2,
    parameter int unsigned CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output seq_state_e       state,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] LV_ASU   = CNT_W'(T_ASU - 1);
    localparam logic [CNT_W-1:0] LV_PULSE = CNT_W'(PULSE_LEN - 1);
    localparam logic [CNT_W-1:0] LV_RD    = CNT_W'(T_RD - 1);

    seq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_write) begin
                        st_d     = ST_WSET;
                        load_val = LV_ASU;
                    end else begin
                        st_d     = ST_RACC;
                        load_val = LV_RD;
                    end
                end
            end
            ST_WSET: begin
                if (expired) begin
                    st_d     = ST_WPULSE;
                    load     = 1'b1;
                    load_val = LV_PULSE;
                end
            end
            ST_WPULSE: if (expired) st_d = ST_WHOLD;
            ST_WHOLD:  st_d = ST_WTURN;
            ST_WTURN:  st_d = ST_IDLE;
            ST_RACC: begin
                if (expired) begin
                    st_d    = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default:   st_d = ST_IDLE;
        endcase
    end

    assign state = st_q;
    assign ready = (st_q == ST_IDLE);
endmodule

// File: rtl/sram_bus_drive.sv
module sram_bus_drive
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output strobe_t           strobes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_din;
        end
    end

    assign strobes   = decode_strobes(state);
    assign mem_addr  = addr_q;
    assign mem_dout  = wdata_q;
    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned T_ASU  = 1,
    parameter int unsigned T_WP   = 2,
    parameter int unsigned T_DSU  = 1,
    parameter int unsigned T_RD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int unsigned PULSE_LEN = imax(T_WP, T_DSU);
    localparam int unsigned MAX_T     = imax(imax(T_ASU, PULSE_LEN), T_RD);
    localparam int unsigned CNT_W     = $clog2(MAX_T + 1);

    seq_state_e       state;
    logic             accept, capture, load, expired;
    logic [CNT_W-1:0] load_val;
    strobe_t          strobes;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .T_ASU     (T_ASU),
        .PULSE_LEN (PULSE_LEN),
        .T_RD      (T_RD),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept),
        .capture   (capture),
        .load      (load),
        .load_val  (load_val)
    );

    sram_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (mem_din),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .strobes   (strobes),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_sel_n   = strobes.sel_n;
    assign mem_sel     = strobes.sel;
    assign mem_rd_n    = strobes.rd_n;
    assign mem_wr_n    = strobes.wr_n;
    assign mem_dout_en = strobes.dout_en;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              mem_dout_en
);
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_rd_n);

    a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |=> mem_rd_n);

    a_r4_pulse_under_select: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_dout_en));

    a_r4_pulse_stable: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> ($stable(mem_addr) && $stable(mem_dout)));

    a_r5_hold_after_end: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_dout_en
                             && $stable(mem_addr) && $stable(mem_dout)));

    a_r7_read_strobes: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> (mem_wr_n && !mem_sel_n && mem_sel));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r11_resp_in_idle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    a_r2_busy_selects: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n) |-> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_sel_n   (mem_sel_n),
    .mem_sel     (mem_sel),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;
    localparam int AW    = 13;
    localparam int DW    = 8;
    localparam int ASU   = 2;
    localparam int WP    = 2;
    localparam int DSU   = 3;
    localparam int RD    = 3;
    localparam int PULSE = (WP > DSU) ? WP : DSU;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dout_en;
    logic [DW-1:0] mem_dout, mem_din;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_ASU(ASU), .T_WP(WP), .T_DSU(DSU), .T_RD(RD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    // memory model: stores on the rising write enable while selected
    always @(posedge mem_wr_n) begin
        if (mem_sel_n === 1'b0 && mem_sel === 1'b1 && mem_dout_en === 1'b1)
            mem[mem_addr] = mem_dout;
    end
    assign mem_din = (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n) ? mem[mem_addr] : 8'h00;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 37 + (a >> 5) + salt);
    endfunction

    // strobe monitor sampled at the falling edge
    int setup_n = 0, pulse_n = 0, rd_n_cnt = 0;
    int contention = 0, turn_bad = 0, wide_rsp = 0;
    bit prev_wr = 1'b1, prev_rd = 1'b1, prev_den = 1'b0, prev_rsp = 1'b0, after_hold = 1'b0;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dout_en && !mem_rd_n) contention++;           // R6
            if (!mem_rd_n && (mem_dout_en || !mem_wr_n)) contention++; // R7
            if (prev_den && !mem_rd_n) turn_bad++;                 // R9
            if (prev_rsp && rsp_valid) wide_rsp++;                 // R8
            if (after_hold) begin                                  // R5 release
                chk("R5 release", {mem_dout_en, mem_sel, mem_sel_n}, 3'b001);
                after_hold = 1'b0;
            end
            if (prev_wr && !mem_wr_n) begin                        // R3
                chk("R3 setup cycles", setup_n, ASU);
                p_addr = mem_addr;
                p_data = mem_dout;
            end
            if (!prev_wr && mem_wr_n) begin                        // R4, R5
                chk("R4 pulse cycles", pulse_n, PULSE);
                chk("R5 hold", {mem_sel_n, mem_sel, mem_dout_en, 1'(mem_addr == p_addr),
                                1'(mem_dout == p_data)}, 5'b01111);
                pulse_n    = 0;
                after_hold = 1'b1;
            end
            if (!prev_rd && mem_rd_n) begin                        // R7
                chk("R7 read cycles", rd_n_cnt, RD);
                rd_n_cnt = 0;
            end
            if (mem_sel_n) setup_n = 0;
            else if (mem_wr_n && mem_rd_n && mem_dout_en && pulse_n == 0 && !after_hold) setup_n++;
            if (!mem_wr_n) pulse_n++;
            if (!mem_rd_n) rd_n_cnt++;
            prev_wr  = mem_wr_n;
            prev_rd  = mem_rd_n;
            prev_den = mem_dout_en;
            prev_rsp = rsp_valid;
        end
    end

    // starts at a falling edge, returns at the first falling edge after acceptance
    task automatic issue(input bit wr, input int a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        int busy;
        @(negedge clk);
        issue(1'b1, a, d);
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
        chk("R2 write busy", busy, ASU + PULSE + 2);
    endtask

    task automatic wait_rsp(input int a, input logic [DW-1:0] exp);
        int lat;
        lat = 1;
        while (!rsp_valid) begin @(negedge clk); lat++; end
        chk("R8 latency", lat, RD + 1);
        chk("R11 ready with response", int'(req_ready), 1);
        chk($sformatf("R10 data @%0d", a), int'(rsp_rdata), int'(exp));
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        @(negedge clk);
        issue(1'b0, a, '0);
        wait_rsp(a, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state after reset
        chk("R1 strobes", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dout_en}, 5'b10110);
        chk("R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);

        for (int a = 0; a < (1 << AW); a += 3) do_write(a, pat(a, 0));
        for (int a = 0; a < (1 << AW); a += 3) do_read(a, pat(a, 0));

        // boundary addresses, back-to-back write then read (R9 turnaround)
        do_write(0, 8'hA5);
        do_read(0, 8'hA5);
        do_write((1 << AW) - 1, 8'h5A);
        do_read((1 << AW) - 1, 8'h5A);
        do_write(3, ~pat(3, 0));
        do_read(3, ~pat(3, 0));

        // R11: next read raised in the response cycle
        @(negedge clk);
        issue(1'b0, 6, '0);
        wait_rsp(6, pat(6, 0));
        issue(1'b0, (1 << AW) - 1, '0);
        wait_rsp((1 << AW) - 1, 8'h5A);
        issue(1'b0, 0, '0);
        wait_rsp(0, 8'hA5);
        @(negedge clk);
        chk("R8 pulse cleared", int'(rsp_valid), 0);

        repeat (4) @(negedge clk);
        chk("R6 contention cycles", contention, 0);
        chk("R9 turnaround violations", turn_bad, 0);
        chk("R8 wide pulses", wide_rsp, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule